// File: doc/BRIEF.md
# Logic Self-Test Controller with Pseudo-Random Stimulus

This block wraps a small combinational circuit under test (CUT) with an on-chip self-test. In normal operation the CUT inputs come straight from the system. A one-cycle `start` pulse hands the CUT inputs to a 4-stage maximal-length shift-register generator. The generator applies a fixed cycle of 15 non-zero patterns.

While the patterns run, the single CUT output bit is fed, one bit per clock, into a serial signature register. That register performs polynomial division and keeps the remainder. When the pattern window closes, the remainder is compared with a golden constant. The block then raises `bist_done` together with a pass/fail result on `bist_good`. Both stay put until the next start.

An n-stage signature lets a faulty stream alias onto the golden value with a probability of roughly 2^-n. The widths, tap mask, seed, division polynomial, pattern count and golden value are all parameters.

Top module: `lbist_ctrl`

## Requirements
- R1: After a synchronous active-high `rst`, `bist_on`, `bist_done` and `bist_good` are 0 and `cut_in` equals `sys_in`.
- R2: Whenever `bist_on` is 0, `cut_in` follows `sys_in` combinationally.
- R3: While `bist_on` is 1, `cut_in` (bit 3 = first stage) never reads 0000. From the start it steps through 0001, 1000, 0100, 0010, 1001, 1100, 0110, 1011, 0101, 1010, 1101, 1110, 1111, 0111, 0011, one pattern per cycle: each step shifts toward bit 0, and the new bit 3 is the XOR of bits 1 and 0.
- R4: Every accepted start, whether from idle or from the done state, begins the sequence again at 0001.
- R5: `bist_on` is high for exactly 15 consecutive cycles after the start edge. `bist_done` rises at the clock edge that ends the 15th cycle, and `bist_on` and `bist_done` are never both high.
- R6: The signature register is cleared to zero when a start is accepted. It absorbs `cut_out` once per `bist_on` cycle, first bit as the highest-degree coefficient, and ends holding the remainder of that bit stream divided by x^4+x+1.
- R7: `bist_good` is 1 only when the final remainder equals the parameter `GOLDEN`, and it is 1 only while `bist_done` is 1.
- R8: `bist_done` and `bist_good` hold until the next start. A start while done clears `bist_done` at that edge and begins a new run.
- R9: A `start` pulse while `bist_on` is high is ignored: the pattern order, the run length and the result are unchanged.
- R10: Asserting `rst` in the middle of a run aborts it: the next cycle shows the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a self-test run when idle or done |
| sys_in | input | PAT_W | Functional stimulus for the CUT |
| cut_out | input | 1 | Output bit returned from the CUT |
| cut_in | output | PAT_W | Stimulus driven into the CUT |
| bist_on | output | 1 | High while patterns are being applied |
| bist_done | output | 1 | High once a run has completed |
| bist_good | output | 1 | Pass flag, meaningful while `bist_done` is high |

## Verification
Two things fall in the same clock edge at the end of a run: the signature absorbs the 15th response bit, and the comparison against `GOLDEN` is taken from that just-updated remainder. A design that compared the stale register would disagree on one bit of the stream. Runs with a healthy CUT model and with a stuck-at CUT model provoke this. The bench judges `bist_good` against a remainder it derives by its own long division.

A second such pair occurs when a start arrives while done. At that single edge the done flag clears, the seed reloads and the first pattern appears. The scoreboard checks the first popped pattern and the cleared flag right after that edge.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } lbist_state_e;

endpackage

// File: rtl/lbist_patgen.sv
// Pseudo-random stimulus source: a right-shifting register whose new top
// bit is the XOR of the tapped stages.
module lbist_patgen #(
    parameter int               W    = 4,
    parameter logic [W-1:0]     TAPS = 4'b0011,
    parameter logic [W-1:0]     SEED = 4'b0001
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] pat
);

    typedef struct packed {
        logic [W-1:0] pat;
    } pg_state_t;

    pg_state_t    r_d, r_q;
    logic [W-1:0] tap_bits;
    logic         fb;

    for (genvar g = 0; g < W; g++) begin : g_tap
        assign tap_bits[g] = TAPS[g] & r_q.pat[g];
    end

    assign fb = ^tap_bits;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.pat = SEED;
        end else if (step) begin
            r_d.pat = {fb, r_q.pat[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.pat <= SEED;
        end else begin
            r_q <= r_d;
        end
    end

    assign pat = r_q.pat;

    // R3: a maximal-length generator never lands on all zeros
    p_never_zero_r3: assert property (@(posedge clk) disable iff (rst)
        pat != '0);

    // R4: an accepted start always restarts from the seed
    p_seed_load_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> pat == SEED);

    // R3: the pattern only moves while a run is stepping it
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(pat));

endmodule

// File: rtl/lbist_sigreg.sv
// Serial signature register: shifts the response stream in and reduces it
// by the feedback polynomial, leaving the division remainder.
module lbist_sigreg #(
    parameter int           W    = 4,
    parameter logic [W-1:0] POLY = 4'b0011   // low coefficients, x^W implied
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] sig_nxt
);

    typedef struct packed {
        logic [W-1:0] sig;
    } sr_state_t;

    sr_state_t    r_d, r_q;
    logic [W-1:0] div_bits;
    logic         carry;

    assign carry = r_q.sig[W-1];

    for (genvar g = 0; g < W; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign div_bits[g] = din ^ (POLY[g] & carry);
        end else begin : g_rest
            assign div_bits[g] = r_q.sig[g-1] ^ (POLY[g] & carry);
        end
    end

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.sig = '0;
        end else if (shift) begin
            r_d.sig = div_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.sig <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sig_nxt = div_bits;

    // R6: compaction starts from an empty remainder
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> r_q.sig == '0);

    // R6: nothing is absorbed outside the pattern window
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !shift) |=> $stable(r_q.sig));

endmodule

// File: rtl/lbist_fsm.sv
// Sequencer: idle -> run for N_PAT cycles -> done (compare latched).
module lbist_fsm
    import lbist_pkg::*;
#(
    parameter int N_PAT = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic match,
    output logic run,
    output logic load,
    output logic done,
    output logic good
);

    localparam int                CNT_W = (N_PAT > 1) ? $clog2(N_PAT) : 1;
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(N_PAT - 1);

    typedef struct packed {
        lbist_state_e     state;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             good;
    } fsm_state_t;

    fsm_state_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        load = 1'b0;
        unique case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    load      = 1'b1;
                    r_d.state = ST_RUN;
                    r_d.cnt   = '0;
                    r_d.done  = 1'b0;
                    r_d.good  = 1'b0;
                end
            end
            ST_RUN: begin
                if (r_q.cnt == LAST) begin
                    r_d.state = ST_DONE;
                    r_d.done  = 1'b1;
                    r_d.good  = match;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.done  <= 1'b0;
            r_q.good  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign run  = (r_q.state == ST_RUN);
    assign done = r_q.done;
    assign good = r_q.good;

    // R5: stimulus phase and completion never overlap
    p_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(run && done));

    // R5: completion is only ever reached from the pattern phase
    p_done_after_run_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(run));

    // R7: a pass is reported only alongside completion
    p_good_in_done_r7: assert property (@(posedge clk) disable iff (rst)
        good |-> done);

    // R8: completion holds until a new start
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R9: start during a run does not end or restart it early
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (run && start && r_q.cnt != LAST) |=> (run && !load));

endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl #(
    parameter int                 PAT_W    = 4,
    parameter logic [PAT_W-1:0]   PAT_TAPS = 4'b0011,
    parameter logic [PAT_W-1:0]   PAT_SEED = 4'b0001,
    parameter int                 SIG_W    = 4,
    parameter logic [SIG_W-1:0]   SIG_POLY = 4'b0011,
    parameter int                 N_PAT    = (2 ** PAT_W) - 1,
    parameter logic [SIG_W-1:0]   GOLDEN   = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PAT_W-1:0] sys_in,
    input  logic             cut_out,
    output logic [PAT_W-1:0] cut_in,
    output logic             bist_on,
    output logic             bist_done,
    output logic             bist_good
);

    logic             run;
    logic             load;
    logic             match;
    logic [PAT_W-1:0] pat;
    logic [SIG_W-1:0] sig_nxt;

    lbist_fsm #(
        .N_PAT (N_PAT)
    ) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .match (match),
        .run   (run),
        .load  (load),
        .done  (bist_done),
        .good  (bist_good)
    );

    lbist_patgen #(
        .W    (PAT_W),
        .TAPS (PAT_TAPS),
        .SEED (PAT_SEED)
    ) u_pat (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .step (run),
        .pat  (pat)
    );

    lbist_sigreg #(
        .W    (SIG_W),
        .POLY (SIG_POLY)
    ) u_sig (
        .clk     (clk),
        .rst     (rst),
        .clr     (load),
        .shift   (run),
        .din     (cut_out),
        .sig_nxt (sig_nxt)
    );

    assign match = (sig_nxt == GOLDEN);

    always_comb begin
        cut_in = sys_in;
        if (run) begin
            cut_in = pat;
        end
    end

    assign bist_on = run;

    // R7: the verdict does not drift while the result is being held
    p_good_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (bist_done && !start) |=> $stable(bist_good));

    // R8: a start taken while done begins a new stimulus phase
    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (bist_done && start) |=> (bist_on && !bist_done));

endmodule

// File: tb/lbist_ctrl_test.sv
module lbist_ctrl_test;

    localparam int CLK_HALF = 10;   // 50 MHz

    function automatic logic [3:0] pat_at(input int i);
        case (i)
            0:  return 4'b0001;
            1:  return 4'b1000;
            2:  return 4'b0100;
            3:  return 4'b0010;
            4:  return 4'b1001;
            5:  return 4'b1100;
            6:  return 4'b0110;
            7:  return 4'b1011;
            8:  return 4'b0101;
            9:  return 4'b1010;
            10: return 4'b1101;
            11: return 4'b1110;
            12: return 4'b1111;
            13: return 4'b0111;
            default: return 4'b0011;
        endcase
    endfunction

    // CUT model; the faulty version has input bit 1 stuck at 0
    function automatic logic cut_fn(input logic [3:0] p, input logic faulty);
        if (faulty) return (p[3] & p[2]) ^ p[0];
        return (p[3] & p[2]) ^ (p[1] | p[0]);
    endfunction

    // Long division of the 15-bit response stream by x^4+x+1
    function automatic logic [3:0] rem_of(input logic faulty);
        logic [14:0] s;
        s = '0;
        for (int i = 0; i < 15; i++) s = {s[13:0], cut_fn(pat_at(i), faulty)};
        for (int b = 14; b >= 4; b--) begin
            if (s[b]) s = s ^ (15'b10011 << (b - 4));
        end
        return s[3:0];
    endfunction

    localparam logic [3:0] GOLD = rem_of(1'b0);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] sys_in = 4'h0;
    logic       cut_out;
    logic [3:0] cut_in;
    logic       bist_on, bist_done, bist_good;
    logic       fault = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_q[$];

    always #(CLK_HALF) clk = ~clk;

    always_comb cut_out = cut_fn(cut_in, fault);

    lbist_ctrl #(.GOLDEN(GOLD)) uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .sys_in    (sys_in),
        .cut_out   (cut_out),
        .cut_in    (cut_in),
        .bist_on   (bist_on),
        .bist_done (bist_done),
        .bist_good (bist_good)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Monitor: pops one expected pattern per cycle of the stimulus phase (R3)
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (!rst && bist_on) begin
                if (exp_q.size() == 0) begin
                    chk("R5 extra pattern cycle", 32'd1, 32'd0);
                end else begin
                    chk("R3 pattern order", {28'd0, cut_in}, {28'd0, exp_q.pop_front()});
                end
            end
        end
    end

    // Driver: queue the expected patterns, launch, wait for completion
    task automatic run_test(input logic faulty, input logic poke, input string tag);
        int on_cnt;
        int guard;
        fault = faulty;
        for (int i = 0; i < 15; i++) exp_q.push_back(pat_at(i));
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk({tag, " R8 done cleared at start"}, {31'd0, bist_done}, 32'd0);
        chk({tag, " R4 first pattern is seed"}, {28'd0, cut_in}, 32'h1);
        on_cnt = 0;
        guard  = 0;
        while (!bist_done && guard < 100) begin
            if (bist_on) on_cnt++;
            start = (poke && (on_cnt == 5 || on_cnt == 14)) ? 1'b1 : 1'b0; // R9
            @(negedge clk);
            #1;
            guard++;
        end
        start = 1'b0;
        chk({tag, " R5 stimulus length"}, on_cnt, 32'd15);
        chk({tag, " R5 done raised"}, {31'd0, bist_done}, 32'd1);
        chk({tag, " R5 on low when done"}, {31'd0, bist_on}, 32'd0);
        // R6/R7: verdict from the bench's own division remainder
        chk({tag, " R6 R7 verdict"}, {31'd0, bist_good},
            {31'd0, (rem_of(faulty) == GOLD)});
        chk({tag, " R3 all patterns consumed"}, exp_q.size(), 32'd0);
    endtask

    initial begin
        #(200000 * 2 * CLK_HALF);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 bist_on", {31'd0, bist_on}, 32'd0);
        chk("R1 bist_done", {31'd0, bist_done}, 32'd0);
        chk("R1 bist_good", {31'd0, bist_good}, 32'd0);
        chk("R1 cut_in mux", {28'd0, cut_in}, {28'd0, sys_in});
        rst = 1'b0;

        // R2: functional path while idle
        @(negedge clk);
        sys_in = 4'hA;
        #1;
        chk("R2 idle mux A", {28'd0, cut_in}, 32'hA);
        sys_in = 4'h5;
        #1;
        chk("R2 idle mux 5", {28'd0, cut_in}, 32'h5);

        run_test(1'b0, 1'b0, "healthy");

        // R8: result held; R2: functional path while done
        repeat (5) @(negedge clk);
        sys_in = 4'hC;
        #1;
        chk("R8 done holds", {31'd0, bist_done}, 32'd1);
        chk("R8 good holds", {31'd0, bist_good}, 32'd1);
        chk("R2 done mux C", {28'd0, cut_in}, 32'hC);

        // R4: restart from done, faulty CUT
        run_test(1'b1, 1'b0, "faulty");

        // R9: start pulses in the middle of a run
        run_test(1'b0, 1'b1, "poked");

        // R10: reset in the middle of a run
        fault = 1'b0;
        for (int i = 0; i < 15; i++) exp_q.push_back(pat_at(i));
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk("R10 on cleared", {31'd0, bist_on}, 32'd0);
        chk("R10 done cleared", {31'd0, bist_done}, 32'd0);
        chk("R10 good cleared", {31'd0, bist_good}, 32'd0);
        chk("R10 mux restored", {28'd0, cut_in}, {28'd0, sys_in});
        rst = 1'b0;
        exp_q.delete();

        run_test(1'b0, 1'b0, "after-reset");

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule